// File: doc/BRIEF.md
# Multi-Level Band Interleave Scheduler

This block sequences a multi-level 2D wavelet decomposition one row band at a time. The row band for each level is two lines high, and the block works through it as a row of 2x2 tiles. Level 0 bands come straight from the source image. A band at level k+1 can run once level k has finished two bands, because those two bands write the two low-low lines that the higher band reads from a per-level repeat store. The schedule therefore moves between levels. A deeper level starts long before the shallower one has covered its whole image, so each level needs only two lines of repeat storage.

For every tile the scheduler gives the row and column processors a level, a band index and a tile column, and raises a one-cycle start. It then waits for the processors to report the tile as done. It also supplies the repeat-store read address for the tile's input lines and the write address for the low-low sample that the tile produces. The filter arithmetic is outside this block. When several levels could run, the deepest ready level goes first. A level stalls when the store it writes still holds two lines that have not been read. A one-cycle done pulse closes the frame.

Top module: `dwt_band_sched`

## Requirements
- R1: While reset is held, and after it until the first `frame_go`, `tile_start` and `frame_done` stay 0.
- R2: Within a band at level k, tiles are issued with `tile_col` counting up from 0 to (IMG_W>>(k+1))-1. `tile_start` is high for exactly one cycle. No new `tile_start` occurs while a tile is outstanding. Within the band, the next `tile_start` comes in the cycle after the cycle in which `tile_done` was accepted.
- R3: At level k, bands are issued with `tile_band` counting up from 0 to (IMG_H>>(k+1))-1. The first tile of a band starts two cycles after the accepting `frame_go` cycle, or two cycles after the `tile_done` that ended the previous band.
- R4: A band at level k≥1 begins only when two level k-1 bands have completed that have not yet been consumed by an earlier level k band.
- R5: When more than one level can start a band, the highest-numbered level is chosen. `tile_level` carries the level as an unsigned binary number.
- R6: A band at level k < LEVELS-1 does not begin while the repeat store of level k+1 holds two unconsumed lines.
- R7: `frame_done` is high for one cycle, in the cycle after the `tile_done` of the last tile of the last band of level LEVELS-1. After that, no tile starts until the next `frame_go`, which restarts the schedule from level 0, band 0.
- R8: For level k≥1, `rpt_rd_en` is 1 and `rpt_rd_addr` = B(k) + 2·`tile_col`, where B(j) is the sum of 2·(IMG_W>>i) for i = 1 … j-1. For level 0, `rpt_rd_en` is 0.
- R9: For level k < LEVELS-1, `rpt_wr_en` is 1 and `rpt_wr_addr` = B(k+1) + (`tile_band` bit 0)·(IMG_W>>(k+1)) + `tile_col`. For the deepest level, `rpt_wr_en` is 0.
- R10: `tile_done` is ignored unless a tile is outstanding and its start cycle is over. `frame_go` is ignored while a frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_go | input | 1 | Starts a new frame when idle |
| tile_done | input | 1 | Processors finished the outstanding tile |
| tile_start | output | 1 | One-cycle start for the tile described by the fields below |
| tile_level | output | LW | Decomposition level of the tile |
| tile_col | output | CW | Tile column within the band |
| tile_band | output | BW | Band index within the level |
| rpt_rd_en | output | 1 | Tile reads its input lines from the repeat store |
| rpt_rd_addr | output | AW | Repeat-store address of the tile's first input sample on line 0 |
| rpt_wr_en | output | 1 | Tile writes a low-low sample into the next level's store |
| rpt_wr_addr | output | AW | Repeat-store address for that low-low sample |
| frame_done | output | 1 | One-cycle pulse when the frame's schedule is complete |

## Verification
The hardest situation to reach is the one where two levels are ready in the same cycle: level 0 has free room in the level-1 store while level 2 already holds two full lines. Only that case shows the priority rule, and only the stall case shows that a shallow level waits for a full store. Both states arise on their own after a few bands of a three-level frame. The bench therefore runs complete frames and checks every issued tile against a behavioural scheduling model, so both cases are compared in order. The response delays vary from tile to tile. Stray `tile_done` and `frame_go` pulses are also injected to show that they leave the schedule unchanged.

// File: rtl/dwt_sched_pkg.sv
package dwt_sched_pkg;

   localparam int MAX_LEVELS = 5;

   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_PICK  = 2'd1,
      S_ISSUE = 2'd2,
      S_WAIT  = 2'd3
   } sched_state_e;

   // number of 2-column tiles in one band of level k
   function automatic int unsigned tiles_at(int unsigned w, int unsigned k);
      return w >> (k + 1);
   endfunction

   // number of 2-line bands in level k
   function automatic int unsigned bands_at(int unsigned h, int unsigned k);
      return h >> (k + 1);
   endfunction

   // first word of the two-line repeat store that feeds level j (j >= 1)
   function automatic int unsigned rpt_base(int unsigned w, int unsigned j);
      int unsigned s;
      s = 0;
      for (int unsigned i = 1; i <= MAX_LEVELS; i++) begin
         if (i < j) s = s + 2 * (w >> i);
      end
      return s;
   endfunction

endpackage

// File: rtl/dwt_lvl_track.sv
module dwt_lvl_track
   import dwt_sched_pkg::*;
#(
   parameter int LVL   = 0,
   parameter int IMG_H = 16,
   parameter int BW    = 3,
   localparam int BCW    = BW + 1,
   localparam int NBANDS = bands_at(IMG_H, LVL)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          fill,
   input  logic          consume,
   output logic          more,
   output logic          avail,
   output logic          room,
   output logic [BW-1:0] band_idx
);

   logic [BCW-1:0] bcnt_q;
   logic [1:0]     lines_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         bcnt_q  <= '0;
         lines_q <= '0;
      end else begin
         if (consume) bcnt_q <= bcnt_q + BCW'(1);
         if (fill) lines_q <= lines_q + 2'd1;
         else if (consume && (LVL > 0)) lines_q <= lines_q - 2'd2;
      end
   end

   assign more     = bcnt_q < BCW'(NBANDS);
   assign avail    = (LVL == 0) ? 1'b1 : (lines_q == 2'd2);
   assign room     = lines_q < 2'd2;
   assign band_idx = bcnt_q[BW-1:0];

   // R4: a band above level 0 only finishes while both of its lines are present
   p_take_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (consume && (LVL > 0)) |-> (lines_q == 2'd2));

   // R3: no band completes beyond the last one of the level
   p_band_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      consume |-> more);

endmodule

// File: rtl/dwt_tile_walk.sv
module dwt_tile_walk
   import dwt_sched_pkg::*;
#(
   parameter int LEVELS = 3,
   parameter int IMG_W  = 32,
   parameter int LW     = 2,
   parameter int CW     = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          adv,
   input  logic [LW-1:0] level,
   output logic [CW-1:0] col,
   output logic          last
);

   logic [CW-1:0] col_q;
   logic [CW-1:0] last_idx;

   always_comb begin
      last_idx = '0;
      for (int k = 0; k < LEVELS; k++) begin
         if (level == LW'(k)) last_idx = CW'(tiles_at(IMG_W, k) - 1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) col_q <= '0;
      else if (load) col_q <= '0;
      else if (adv && (col_q != last_idx)) col_q <= col_q + CW'(1);
   end

   assign col  = col_q;
   assign last = (col_q == last_idx);

   // R2: the column never runs past the band's last tile
   p_col_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      col_q <= last_idx);

endmodule

// File: rtl/dwt_rpt_addr.sv
module dwt_rpt_addr
   import dwt_sched_pkg::*;
#(
   parameter int LEVELS = 3,
   parameter int IMG_W  = 32,
   parameter int LW     = 2,
   parameter int CW     = 4,
   parameter int AW     = 6
) (
   input  logic [LW-1:0] level,
   input  logic [CW-1:0] col,
   input  logic          parity,
   output logic          rd_en,
   output logic [AW-1:0] rd_addr,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr
);

   always_comb begin
      rd_en   = 1'b0;
      rd_addr = '0;
      wr_en   = 1'b0;
      wr_addr = '0;
      for (int k = 0; k < LEVELS; k++) begin
         if (level == LW'(k)) begin
            if (k > 0) begin
               rd_en   = 1'b1;
               rd_addr = AW'(rpt_base(IMG_W, k)) + AW'({col, 1'b0});
            end
            if (k < LEVELS - 1) begin
               wr_en   = 1'b1;
               wr_addr = AW'(rpt_base(IMG_W, k + 1))
                       + (parity ? AW'(IMG_W >> (k + 1)) : AW'(0))
                       + AW'(col);
            end
         end
      end
   end

endmodule

// File: rtl/dwt_band_sched.sv
module dwt_band_sched
   import dwt_sched_pkg::*;
#(
   parameter int LEVELS = 3,
   parameter int IMG_W  = 32,
   parameter int IMG_H  = 16,
   localparam int LW    = (LEVELS > 1) ? $clog2(LEVELS) : 1,
   localparam int CW    = $clog2(IMG_W / 2),
   localparam int BW    = $clog2(IMG_H / 2),
   localparam int AW    = $clog2(2 * IMG_W),
   localparam int STORE = rpt_base(IMG_W, LEVELS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_go,
   input  logic          tile_done,
   output logic          tile_start,
   output logic [LW-1:0] tile_level,
   output logic [CW-1:0] tile_col,
   output logic [BW-1:0] tile_band,
   output logic          rpt_rd_en,
   output logic [AW-1:0] rpt_rd_addr,
   output logic          rpt_wr_en,
   output logic [AW-1:0] rpt_wr_addr,
   output logic          frame_done
);

   // elaboration-time parameter checks
   if (LEVELS < 1 || LEVELS > MAX_LEVELS) begin : g_bad_levels
      $error("dwt_band_sched: LEVELS must lie in 1..5");
   end
   if (((IMG_W & (IMG_W - 1)) != 0) || (IMG_W < (1 << (LEVELS + 1)))) begin : g_bad_w
      $error("dwt_band_sched: IMG_W must be a power of two, at least 2**(LEVELS+1)");
   end
   if (((IMG_H & (IMG_H - 1)) != 0) || (IMG_H < (1 << (LEVELS + 1)))) begin : g_bad_h
      $error("dwt_band_sched: IMG_H must be a power of two, at least 2**(LEVELS+1)");
   end

   sched_state_e  state_q;
   logic [LW-1:0] lvl_q;
   logic          done_q;

   logic [LEVELS-1:0] more, avail, room, fill, consume, ready;
   logic [BW-1:0]     band_idx [LEVELS];

   logic          pick_any;
   logic [LW-1:0] pick_lvl;
   logic [CW-1:0] col;
   logic          col_last;
   logic [BW-1:0] cur_band;
   logic          band_end, frame_end, clear, accept;

   assign clear    = (state_q == S_IDLE) && frame_go;
   assign accept   = (state_q == S_WAIT) && tile_done;
   assign band_end = accept && col_last;

   // one tracker per level; each level feeds the repeat store of the next
   for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
      dwt_lvl_track #(.LVL(k), .IMG_H(IMG_H), .BW(BW)) u_trk (
         .clk      (clk),
         .rst_n    (rst_n),
         .clear    (clear),
         .fill     (fill[k]),
         .consume  (consume[k]),
         .more     (more[k]),
         .avail    (avail[k]),
         .room     (room[k]),
         .band_idx (band_idx[k])
      );
      assign consume[k] = band_end && (lvl_q == LW'(k));
      if (k == 0) begin : g_src
         assign fill[k] = 1'b0;
      end else begin : g_rep
         assign fill[k] = consume[k-1];
      end
      if (k == LEVELS - 1) begin : g_deep
         assign ready[k] = more[k] && avail[k];
      end else begin : g_mid
         assign ready[k] = more[k] && avail[k] && room[k+1];
      end

      // R6: a line is only written into a store that has a free slot
      p_fill_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
         fill[k] |-> room[k]);
   end

   // deepest ready level wins
   always_comb begin
      pick_any = 1'b0;
      pick_lvl = '0;
      for (int k = 0; k < LEVELS; k++) begin
         if (ready[k]) begin
            pick_any = 1'b1;
            pick_lvl = LW'(k);
         end
      end
   end

   always_comb begin
      cur_band = '0;
      for (int k = 0; k < LEVELS; k++) begin
         if (lvl_q == LW'(k)) cur_band = band_idx[k];
      end
   end

   assign frame_end = band_end && (lvl_q == LW'(LEVELS - 1))
                   && (cur_band == BW'(bands_at(IMG_H, LEVELS - 1) - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         lvl_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            S_IDLE: if (frame_go) state_q <= S_PICK;
            S_PICK: if (pick_any) begin
               lvl_q   <= pick_lvl;
               state_q <= S_ISSUE;
            end
            S_ISSUE: state_q <= S_WAIT;
            S_WAIT: if (tile_done) begin
               if (!col_last) state_q <= S_ISSUE;
               else if (frame_end) begin
                  state_q <= S_IDLE;
                  done_q  <= 1'b1;
               end else state_q <= S_PICK;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   dwt_tile_walk #(.LEVELS(LEVELS), .IMG_W(IMG_W), .LW(LW), .CW(CW)) u_walk (
      .clk   (clk),
      .rst_n (rst_n),
      .load  ((state_q == S_PICK) && pick_any),
      .adv   (accept),
      .level (lvl_q),
      .col   (col),
      .last  (col_last)
   );

   dwt_rpt_addr #(.LEVELS(LEVELS), .IMG_W(IMG_W), .LW(LW), .CW(CW), .AW(AW)) u_addr (
      .level   (lvl_q),
      .col     (col),
      .parity  (cur_band[0]),
      .rd_en   (rpt_rd_en),
      .rd_addr (rpt_rd_addr),
      .wr_en   (rpt_wr_en),
      .wr_addr (rpt_wr_addr)
   );

   assign tile_start = (state_q == S_ISSUE);
   assign tile_level = lvl_q;
   assign tile_col   = col;
   assign tile_band  = cur_band;
   assign frame_done = done_q;

   // R2: a start is a single-cycle pulse
   p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tile_start |=> !tile_start);

   // R7: done is a single-cycle pulse followed by no tile
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> (!frame_done && !tile_start));

   // R8: reads stay inside the repeat store
   p_rd_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_rd_en |-> (rpt_rd_addr < AW'(STORE)));

endmodule

// File: tb/sim_dwt_band_sched.sv
module sim_dwt_band_sched;

   localparam int LEVELS = 3;
   localparam int IMG_W  = 32;
   localparam int IMG_H  = 16;
   localparam int LW = 2, CW = 4, BW = 3, AW = 6;
   localparam int MAXT = 512;

   logic          clk, rst_n, frame_go, tile_done;
   logic          tile_start, rpt_rd_en, rpt_wr_en, frame_done;
   logic [LW-1:0] tile_level;
   logic [CW-1:0] tile_col;
   logic [BW-1:0] tile_band;
   logic [AW-1:0] rpt_rd_addr, rpt_wr_addr;

   dwt_band_sched #(.LEVELS(LEVELS), .IMG_W(IMG_W), .IMG_H(IMG_H)) u0 (
      .clk(clk), .rst_n(rst_n), .frame_go(frame_go), .tile_done(tile_done),
      .tile_start(tile_start), .tile_level(tile_level), .tile_col(tile_col),
      .tile_band(tile_band), .rpt_rd_en(rpt_rd_en), .rpt_rd_addr(rpt_rd_addr),
      .rpt_wr_en(rpt_wr_en), .rpt_wr_addr(rpt_wr_addr), .frame_done(frame_done)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   int n_exp;
   int e_lvl [MAXT], e_band [MAXT], e_col [MAXT];
   int e_rd [MAXT], e_rda [MAXT], e_wr [MAXT], e_wra [MAXT];
   bit e_end [MAXT], e_final [MAXT];

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   function automatic int store_base(int j);
      int s = 0;
      for (int i = 1; i < j; i++) s += 2 * (IMG_W >> i);
      return s;
   endfunction

   // behavioural schedule: deepest ready level first, two lines per store
   task automatic build_model();
      int lines [6];
      int done [6];
      int pick;
      bit rdy;
      for (int k = 0; k < 6; k++) begin lines[k] = 0; done[k] = 0; end
      n_exp = 0;
      while (done[LEVELS-1] < (IMG_H >> LEVELS)) begin
         pick = -1;
         for (int k = 0; k < LEVELS; k++) begin
            rdy = (done[k] < (IMG_H >> (k + 1)))
               && (k == 0 || lines[k] == 2)
               && (k == LEVELS - 1 || lines[k+1] < 2);
            if (rdy) pick = k;
         end
         if (pick < 0) break;
         for (int c = 0; c < (IMG_W >> (pick + 1)); c++) begin
            e_lvl[n_exp]  = pick;
            e_band[n_exp] = done[pick];
            e_col[n_exp]  = c;
            e_rd[n_exp]   = (pick > 0) ? 1 : 0;
            e_rda[n_exp]  = store_base(pick) + 2 * c;
            e_wr[n_exp]   = (pick < LEVELS - 1) ? 1 : 0;
            e_wra[n_exp]  = store_base(pick + 1) + (done[pick] % 2) * (IMG_W >> (pick + 1)) + c;
            e_end[n_exp]  = (c == (IMG_W >> (pick + 1)) - 1);
            e_final[n_exp] = e_end[n_exp] && (pick == LEVELS - 1)
                          && (done[pick] == (IMG_H >> LEVELS) - 1);
            n_exp++;
         end
         if (pick > 0) lines[pick] -= 2;
         if (pick < LEVELS - 1) lines[pick+1] += 1;
         done[pick] += 1;
      end
   endtask

   task automatic run_frame(int pat);
      @(negedge clk); frame_go = 1'b1;
      @(negedge clk); frame_go = 1'b0;
      chk("R3 no start in pick cycle", int'(tile_start), 0);
      @(negedge clk);
      for (int i = 0; i < n_exp; i++) begin
         chk("R2 R3 tile start", int'(tile_start), 1);
         chk("R7 done low mid frame", int'(frame_done), 0);
         chk("R4 R5 R6 level", int'(tile_level), e_lvl[i]);
         chk("R3 band", int'(tile_band), e_band[i]);
         chk("R2 col", int'(tile_col), e_col[i]);
         chk("R8 rd_en", int'(rpt_rd_en), e_rd[i]);
         if (e_rd[i] != 0) chk("R8 rd_addr", int'(rpt_rd_addr), e_rda[i]);
         chk("R9 wr_en", int'(rpt_wr_en), e_wr[i]);
         if (e_wr[i] != 0) chk("R9 wr_addr", int'(rpt_wr_addr), e_wra[i]);
         if ((i + pat) % 5 == 0) tile_done = 1'b1;   // early, must be ignored
         @(negedge clk); tile_done = 1'b0;
         chk("R2 R10 no start while busy", int'(tile_start), 0);
         if ((i + pat) % 7 == 3) frame_go = 1'b1;    // must be ignored
         for (int d = 0; d < (i * pat) % 4; d++) begin
            @(negedge clk); frame_go = 1'b0;
            chk("R2 R10 no start while busy", int'(tile_start), 0);
         end
         tile_done = 1'b1;
         @(negedge clk); tile_done = 1'b0; frame_go = 1'b0;
         if (e_final[i]) begin
            chk("R7 done pulse", int'(frame_done), 1);
            chk("R7 no start at done", int'(tile_start), 0);
         end else if (e_end[i]) begin
            chk("R3 band gap", int'(tile_start), 0);
            @(negedge clk);
         end
      end
      @(negedge clk);
      chk("R7 done one cycle", int'(frame_done), 0);
      for (int j = 0; j < 6; j++) begin
         tile_done = (j % 2 == 0);
         @(negedge clk);
         chk("R7 R10 idle after frame", int'(tile_start), 0);
      end
      tile_done = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0; frame_go = 1'b0; tile_done = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 start in reset", int'(tile_start), 0);
      chk("R1 done in reset", int'(frame_done), 0);
      rst_n = 1'b1;
      @(negedge clk); tile_done = 1'b1;
      @(negedge clk); tile_done = 1'b0;
      chk("R1 R10 idle ignores done", int'(tile_start), 0);
      repeat (3) begin
         @(negedge clk);
         chk("R1 idle start", int'(tile_start), 0);
         chk("R1 idle done", int'(frame_done), 0);
      end
      build_model();
      run_frame(1);
      run_frame(3);
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL R7 watchdog act=running exp=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule